// File: doc/BRIEF.md
# SPI Receive Flag and Overrun Controller

This block holds the receive status of an SPI peripheral. It sits between the shift-register core, which pulses a strobe each time a byte has been fully shifted in, and the CPU register interface, which reports status-register reads and data-register reads. The block keeps one buffered byte, a receive-full flag and an overrun flag. It also drives one interrupt request, which is shared by the receiver and the error sources.

A flag is cleared by a two-step sequence. First the CPU reads the status register while the flag is set. Then it reads the data register. The block records which flags each status read saw, and a later data read clears exactly those flags. On overrun the block keeps the older byte and drops every newer byte until software services the overrun. This shows software which byte survived and that later bytes were lost.

Top module: `spi_rx_status`

## Requirements
- R1: When a reception completes with both flags clear, the byte is written to `rd_data` and `full_flag` rises on the next clock.
- R2: When a reception completes while `full_flag` is set and no clear of it happens in that cycle, `ovr_flag` rises and the new byte is discarded.
- R3: While `ovr_flag` is set, `rd_data` keeps the byte that was present before the overrun.
- R4: `full_flag` clears when a `data_rd` pulse follows a `stat_rd` pulse that was issued while `full_flag` was set.
- R5: `ovr_flag` clears when a `data_rd` pulse follows a `stat_rd` pulse that saw it set. The `rd_data` value presented during that data read is the retained older byte.
- R6: While `ovr_flag` is set, completed receptions neither set `full_flag` nor change `rd_data`.
- R7: `irq` is a register. When the inputs have been steady for one cycle it equals `full_flag | (err_ie & (ovr_flag | fault))`. The error sources reach `irq` only when `err_ie` is high.
- R8: A `data_rd` that no status read observing the flag preceded leaves that flag unchanged. This includes a flag that was set after the last status read.
- R9: A reception in the same cycle as a clearing `data_rd` is handled after the clear. A byte that arrives as `full_flag` is being cleared is loaded, and `ovr_flag` stays clear.
- R10: Synchronous active-high `rst` clears both flags, `irq` and `rd_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | 1 | One-cycle strobe from the shift core: a byte is complete |
| rx_byte | input | DATA_W | Byte delivered with `rx_done` |
| stat_rd | input | 1 | CPU read of the status register |
| data_rd | input | 1 | CPU read of the data register |
| err_ie | input | 1 | Error interrupt enable |
| fault | input | FAULT_N | Other error requests, such as a mode fault, that share the interrupt |
| rd_data | output | DATA_W | Buffered receive byte |
| full_flag | output | 1 | Receive-full flag |
| ovr_flag | output | 1 | Overrun flag |
| irq | output | 1 | Shared receiver/error interrupt request |

## Verification
Two functions can fall in the same cycle: a completed reception (`rx_done`) and a clearing data read (`data_rd`). The bench provokes this by doing a status read while `full_flag` is set and then pulsing `rx_done` and `data_rd` together. The result counts as correct if the new byte is in `rd_data`, `full_flag` is still set and `ovr_flag` stays low. Separately, the scoreboard checks that the data read in that cycle still returned the old byte.

// File: rtl/spi_rxf_pkg.sv
package spi_rxf_pkg;
  typedef struct packed {
    logic full;
    logic ovr;
  } rxf_flags_t;

  localparam rxf_flags_t FLAGS_NONE = '{full: 1'b0, ovr: 1'b0};
endpackage

// File: rtl/spi_rxf_seen.sv
// Records which flags the most recent status read observed; a data read
// turns that record into a clear mask and consumes it.
module spi_rxf_seen
  import spi_rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stat_rd,
  input  logic       data_rd,
  input  rxf_flags_t flags_q,
  output rxf_flags_t clr_mask,
  output rxf_flags_t seen_q
);
  always_comb begin
    clr_mask = data_rd ? seen_q : FLAGS_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= FLAGS_NONE;
    end else if (stat_rd) begin
      // a flag being cleared in this same cycle is not recorded as seen
      seen_q <= flags_q & ~clr_mask;
    end else if (data_rd) begin
      seen_q <= FLAGS_NONE;
    end
  end

  AST_UNSEEN_KEEP: assert property (@(posedge clk) disable iff (rst)
    data_rd && !seen_q.full && flags_q.full |=> flags_q.full) // R8
    else $error("unobserved full flag was cleared");
endmodule

// File: rtl/spi_rxf_flags.sv
// Flag next-state: clears are applied first, then the reception.
module spi_rxf_flags
  import spi_rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_done,
  input  rxf_flags_t clr_mask,
  output rxf_flags_t flags_q,
  output rxf_flags_t flags_d,
  output logic       load
);
  rxf_flags_t after_clr;

  always_comb begin
    after_clr = flags_q & ~clr_mask;
    flags_d   = after_clr;
    load      = 1'b0;
    if (rx_done) begin
      if (after_clr.ovr) begin
        // overrun pending: byte dropped, nothing changes
      end else if (after_clr.full) begin
        flags_d.ovr = 1'b1;
      end else begin
        flags_d.full = 1'b1;
        load         = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= FLAGS_NONE;
    else     flags_q <= flags_d;
  end

  AST_FULL_SET: assert property (@(posedge clk) disable iff (rst)
    rx_done && !flags_q.full && !flags_q.ovr |=> flags_q.full) // R1
    else $error("reception into empty buffer did not set full");

  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    rx_done && flags_q.full && !clr_mask.full |=> flags_q.ovr) // R2
    else $error("reception into full buffer did not set overrun");

  AST_NO_FULL_IN_OVR: assert property (@(posedge clk) disable iff (rst)
    flags_q.ovr && !clr_mask.ovr && !flags_q.full |=> !flags_q.full) // R6
    else $error("full set while overrun pending");
endmodule

// File: rtl/spi_rxf_buf.sv
// Single-entry receive data register.
module spi_rxf_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst)       data_q <= '0;
    else if (load) data_q <= din;
  end
endmodule

// File: rtl/spi_rxf_irq.sv
// Registered shared interrupt: receiver always, error sources gated.
module spi_rxf_irq #(
  parameter int FAULT_N = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               full_d,
  input  logic               ovr_d,
  input  logic               err_ie,
  input  logic [FAULT_N-1:0] fault,
  output logic               irq_q
);
  logic err_any;

  always_comb err_any = ovr_d | (|fault);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= full_d | (err_ie & err_any);
  end
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_rxf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FAULT_N = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_done,
  input  logic [DATA_W-1:0]  rx_byte,
  input  logic               stat_rd,
  input  logic               data_rd,
  input  logic               err_ie,
  input  logic [FAULT_N-1:0] fault,
  output logic [DATA_W-1:0]  rd_data,
  output logic               full_flag,
  output logic               ovr_flag,
  output logic               irq
);
  rxf_flags_t flags_q, flags_d, clr_mask, seen_q;
  logic       load;

  spi_rxf_seen u_seen (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .data_rd(data_rd),
    .flags_q(flags_q), .clr_mask(clr_mask), .seen_q(seen_q)
  );

  spi_rxf_flags u_flags (
    .clk(clk), .rst(rst), .rx_done(rx_done), .clr_mask(clr_mask),
    .flags_q(flags_q), .flags_d(flags_d), .load(load)
  );

  spi_rxf_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .load(load), .din(rx_byte), .data_q(rd_data)
  );

  spi_rxf_irq #(.FAULT_N(FAULT_N)) u_irq (
    .clk(clk), .rst(rst), .full_d(flags_d.full), .ovr_d(flags_d.ovr),
    .err_ie(err_ie), .fault(fault), .irq_q(irq)
  );

  assign full_flag = flags_q.full;
  assign ovr_flag  = flags_q.ovr;

  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (rst)
    rx_done && !full_flag && !ovr_flag |=> rd_data == $past(rx_byte)) // R1
    else $error("received byte not buffered");

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
    ovr_flag && !data_rd |=> $stable(rd_data)) // R3
    else $error("buffer changed during overrun");

  AST_FULL_IRQ: assert property (@(posedge clk) disable iff (rst)
    full_flag |-> irq) // R7
    else $error("full flag without interrupt");

  AST_SEEN_SUBSET: assert property (@(posedge clk) disable iff (rst)
    $rose(seen_q.ovr) |-> ovr_flag || $past(ovr_flag)) // R5
    else $error("overrun recorded as seen while clear");
endmodule

// File: tb/test_spi_rx_status.sv
module test_spi_rx_status;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rx_done = 1'b0;
  logic [W-1:0] rx_byte = '0;
  logic         stat_rd = 1'b0;
  logic         data_rd = 1'b0;
  logic         err_ie = 1'b0;
  logic [0:0]   fault = 1'b0;
  logic [W-1:0] rd_data;
  logic         full_flag, ovr_flag, irq;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [W-1:0] exp_q[$];

  always #5 clk = ~clk;

  spi_rx_status i_spi_rx_status (
    .clk(clk), .rst(rst), .rx_done(rx_done), .rx_byte(rx_byte),
    .stat_rd(stat_rd), .data_rd(data_rd), .err_ie(err_ie), .fault(fault),
    .rd_data(rd_data), .full_flag(full_flag), .ovr_flag(ovr_flag), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every data read is compared with the scoreboard head
  always @(negedge clk) begin
    if (data_rd && !rst) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 scoreboard empty", rd_data, 0);
      end else begin
        automatic logic [W-1:0] e = exp_q.pop_front();
        check(rd_data == e, "R5 data read value", rd_data, e);
      end
    end
  end

  task automatic cyc(input bit rx, input logic [W-1:0] b, input bit sr, input bit dr);
    @(posedge clk); #2;
    rx_done = rx; rx_byte = b; stat_rd = sr; data_rd = dr;
    @(posedge clk); #2;
    rx_done = 1'b0; stat_rd = 1'b0; data_rd = 1'b0;
  endtask

  task automatic recv(input logic [W-1:0] b);
    cyc(1'b1, b, 1'b0, 1'b0);
  endtask
  task automatic sread();
    cyc(1'b0, '0, 1'b1, 1'b0);
  endtask
  task automatic dread(input logic [W-1:0] e);
    exp_q.push_back(e);
    cyc(1'b0, '0, 1'b0, 1'b1);
  endtask
  task automatic flags(input string req, input bit f, input bit o, input logic [W-1:0] d);
    check(full_flag == f, {req, " full"}, full_flag, f);
    check(ovr_flag == o, {req, " ovr"}, ovr_flag, o);
    check(rd_data == d, {req, " data"}, rd_data, d);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2; rst = 1'b0;
    @(negedge clk);
    flags("R10 reset", 1'b0, 1'b0, 8'h00);
    check(irq == 1'b0, "R10 irq", irq, 0);

    recv(8'hA5);
    flags("R1 load", 1'b1, 1'b0, 8'hA5);
    check(irq == 1'b1, "R7 full irq", irq, 1);

    dread(8'hA5);                         // no status read before
    flags("R8 unseen keep", 1'b1, 1'b0, 8'hA5);

    sread(); dread(8'hA5);
    flags("R4 full clear", 1'b0, 1'b0, 8'hA5);
    check(irq == 1'b0, "R7 irq idle", irq, 0);

    // overrun sequence
    recv(8'h11); sread();
    recv(8'h22);
    flags("R2 overrun", 1'b1, 1'b1, 8'h11);
    recv(8'h33);
    flags("R3 hold", 1'b1, 1'b1, 8'h11);
    dread(8'h11);                         // status saw full only
    flags("R8 ovr not seen", 1'b0, 1'b1, 8'h11);
    recv(8'h44);
    flags("R6 no full in ovr", 1'b0, 1'b1, 8'h11);

    // interrupt gating while overrun set, full clear
    check(irq == 1'b0, "R7 ovr gated off", irq, 0);
    err_ie = 1'b1; cyc(1'b0, '0, 1'b0, 1'b0);
    check(irq == 1'b1, "R7 ovr gated on", irq, 1);

    sread(); dread(8'h11);
    flags("R5 ovr clear", 1'b0, 1'b0, 8'h11);
    check(irq == 1'b0, "R7 after clear", irq, 0);

    fault = 1'b1; cyc(1'b0, '0, 1'b0, 1'b0);
    check(irq == 1'b1, "R7 fault on", irq, 1);
    err_ie = 1'b0; cyc(1'b0, '0, 1'b0, 1'b0);
    check(irq == 1'b0, "R7 fault gated", irq, 0);
    fault = 1'b0;

    recv(8'h55);
    flags("R1 reload", 1'b1, 1'b0, 8'h55);

    // same-cycle reception and clearing read
    sread();
    exp_q.push_back(8'h55);
    cyc(1'b1, 8'h66, 1'b0, 1'b1);
    flags("R9 same cycle", 1'b1, 1'b0, 8'h66);

    rst = 1'b1; cyc(1'b0, '0, 1'b0, 1'b0); rst = 1'b0;
    flags("R10 second reset", 1'b0, 1'b0, 8'h00);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule